// File: doc/BRIEF.md
# Multi-Microphone PDM Capture Front-End

This block sits between up to four one-bit pulse-density microphones and the receive holding register of an audio capture unit. It generates the microphone clock from the core clock. Each of two shared data lines carries two microphones: one drives its bit for the rising clock edge and the other for the falling edge. The block samples every line at both edges. It then steers one of the four captured bits to each logical channel, using that channel's own line and edge select, and presents the per-channel bit vector once per microphone clock period to an external decimation filter.

The decimation filter returns one 24-bit sample per channel per output-rate period as a single frame strobe. The block queues the enabled channels of that frame and hands them one at a time, lowest index first, through a ready/valid handshake into a single holding register. Each word carries the channel index in its top byte. Software reads the holding register through a read strobe. Sticky flags report a frame that displaced undelivered words and a read of an empty register. A synchronous software-reset command returns all capture state and flags to their reset values.

Top module: `pdm_capture_frontend`

## Requirements
- R1: `pdm_clk` is low after reset and toggles every `DIV_HALF` core cycles, giving a period of `2*DIV_HALF` core cycles.
- R2: For channel n, `line_sel[n]` chooses data line 0 (value 0) or line 1 (value 1), and `edge_sel[n]` chooses the bit captured at the rising edge (value 0) or at the falling edge (value 1). `pdm_bits[n]` shows the bit of the same clock period selected this way.
- R3: A channel whose bit in `ch_en` is 0 shows 0 on `pdm_bits` and produces no word in the holding register.
- R4: `bit_valid` is a single-cycle pulse, raised once per microphone clock period after the falling-edge capture.
- R5: After a frame strobe, every enabled channel of the frame is delivered exactly once, in ascending channel order. A word is loaded only while the holding register is empty.
- R6: A delivered word holds the channel index in bits [31:24] and that channel's 24-bit sample in bits [23:0].
- R7: `rx_ready` rises when a word is loaded and falls on the cycle after a read strobe.
- R8: A frame strobe that arrives while words of the previous frame are still undelivered sets the sticky `ovr_flag`. The undelivered words are replaced by the new frame. The word already in the holding register is kept.
- R9: A read strobe while `rx_ready` is low sets the sticky `udr_flag` and leaves `rx_ready` low.
- R10: A `sw_rst` pulse clears `rx_ready`, both flags, pending words, `bit_valid`, and the clock generator, which restarts with `pdm_clk` low.
- R11: After `rst_n`, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_rst | input | 1 | Synchronous software-reset command |
| ch_en | input | NCH | Per-channel enable |
| line_sel | input | NCH | Per-channel data-line select |
| edge_sel | input | NCH | Per-channel edge select (0 rising, 1 falling) |
| pdm_clk | output | 1 | Microphone clock |
| pdm_line | input | 2 | Shared PDM data lines |
| bit_valid | output | 1 | Per-period strobe for `pdm_bits` |
| pdm_bits | output | NCH | Routed per-channel bits toward the filter |
| smp_valid | input | 1 | Frame strobe from the filter |
| smp_data | input | NCH*24 | Per-channel samples, channel n at [24n+23:24n] |
| rd_en | input | 1 | Holding-register read strobe |
| rd_data | output | 32 | Holding-register contents |
| rx_ready | output | 1 | Holding register has an unread word |
| ovr_flag | output | 1 | Sticky overrun flag |
| udr_flag | output | 1 | Sticky underrun flag |

## Verification
The routing path is swept over all 256 combinations of line and edge selects, each against all 16 values of the four microphone bits. A wrong line or wrong edge on any channel therefore disagrees with the expected value for at least one pattern. With all bits driven high, every enable mask is applied, which separates masking from routing. The frame path is run for all 16 enable masks with distinct samples per channel and mask, so that ordering, tagging, dropped words and duplicated words each give a distinct mismatch. Directed sequences then cover overrun replacement, underrun, and software reset with the flags set.

// File: rtl/pdmcap_pkg.sv
package pdmcap_pkg;
  localparam int SAMPLE_W = 24;
  localparam int TAG_W    = 8;
  localparam int WORD_W   = SAMPLE_W + TAG_W;
  localparam int LINES    = 2;

  // pick one captured bit by line and edge
  function automatic logic route_bit(input logic [LINES-1:0] rise_bits,
                                     input logic [LINES-1:0] fall_bits,
                                     input logic line, input logic edge_fall);
    return edge_fall ? fall_bits[line] : rise_bits[line];
  endfunction

  function automatic logic [WORD_W-1:0] pack_word(input logic [TAG_W-1:0] tag,
                                                  input logic [SAMPLE_W-1:0] smp);
    return {tag, smp};
  endfunction
endpackage

// File: rtl/pdmcap_clkgen.sv
module pdmcap_clkgen #(
  parameter int DIV_HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_rst,
  output logic pdm_clk,
  output logic rise_stb,
  output logic fall_stb
);
  localparam int CW = (DIV_HALF < 2) ? 1 : $clog2(DIV_HALF);

  logic [CW-1:0] cnt;
  logic          terminal;

  assign terminal = (cnt == CW'(DIV_HALF - 1));
  assign rise_stb = terminal && !pdm_clk;
  assign fall_stb = terminal && pdm_clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      pdm_clk <= 1'b0;
    end else if (sw_rst) begin
      cnt     <= '0;
      pdm_clk <= 1'b0;
    end else if (terminal) begin
      cnt     <= '0;
      pdm_clk <= ~pdm_clk;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/pdmcap_capture.sv
module pdmcap_capture
  import pdmcap_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_rst,
  input  logic             rise_stb,
  input  logic             fall_stb,
  input  logic [LINES-1:0] pdm_line,
  input  logic [NCH-1:0]   ch_en,
  input  logic [NCH-1:0]   line_sel,
  input  logic [NCH-1:0]   edge_sel,
  output logic             bit_valid,
  output logic [NCH-1:0]   pdm_bits
);
  logic [LINES-1:0] rise_q, fall_q;
  logic             period_done;
  logic [NCH-1:0]   routed;

  for (genvar n = 0; n < NCH; n++) begin : g_route
    assign routed[n] = ch_en[n] && route_bit(rise_q, fall_q, line_sel[n], edge_sel[n]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q      <= '0;
      fall_q      <= '0;
      period_done <= 1'b0;
      bit_valid   <= 1'b0;
      pdm_bits    <= '0;
    end else if (sw_rst) begin
      rise_q      <= '0;
      fall_q      <= '0;
      period_done <= 1'b0;
      bit_valid   <= 1'b0;
      pdm_bits    <= '0;
    end else begin
      if (rise_stb) rise_q <= pdm_line;
      if (fall_stb) fall_q <= pdm_line;
      period_done <= fall_stb;
      bit_valid   <= period_done;
      if (period_done) pdm_bits <= routed;
    end
  end
endmodule

// File: rtl/pdmcap_sequencer.sv
module pdmcap_sequencer
  import pdmcap_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sw_rst,
  input  logic                    smp_valid,
  input  logic [NCH*SAMPLE_W-1:0] smp_data,
  input  logic [NCH-1:0]          ch_en,
  input  logic                    out_ready,
  output logic                    out_valid,
  output logic [WORD_W-1:0]       out_word,
  output logic                    ovr_evt
);
  localparam int IDX_W = $clog2(NCH);

  logic [NCH-1:0]      pend, pend_left, sel_oh;
  logic [IDX_W-1:0]    sel_idx;
  logic [SAMPLE_W-1:0] store [NCH];
  logic                send;

  always_comb begin
    sel_idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (pend[i]) sel_idx = IDX_W'(i);
    end
  end

  assign out_valid = |pend;
  assign send      = out_valid && out_ready;
  assign sel_oh    = send ? (NCH'(1) << sel_idx) : '0;
  assign pend_left = pend & ~sel_oh;
  assign ovr_evt   = smp_valid && (|pend_left);
  assign out_word  = pack_word(TAG_W'(sel_idx), store[sel_idx]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pend <= '0;
    else if (sw_rst)     pend <= '0;
    else if (smp_valid)  pend <= ch_en;
    else                 pend <= pend_left;
  end

  for (genvar n = 0; n < NCH; n++) begin : g_store
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         store[n] <= '0;
      else if (sw_rst)    store[n] <= '0;
      else if (smp_valid) store[n] <= smp_data[n*SAMPLE_W +: SAMPLE_W];
    end
  end
endmodule

// File: rtl/pdmcap_holdreg.sv
module pdmcap_holdreg
  import pdmcap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_rst,
  input  logic              push,
  input  logic [WORD_W-1:0] word,
  input  logic              rd_en,
  input  logic              ovr_evt,
  output logic [WORD_W-1:0] rd_data,
  output logic              rx_ready,
  output logic              ovr_flag,
  output logic              udr_flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rx_ready <= 1'b0;
      ovr_flag <= 1'b0;
      udr_flag <= 1'b0;
    end else if (sw_rst) begin
      rd_data  <= '0;
      rx_ready <= 1'b0;
      ovr_flag <= 1'b0;
      udr_flag <= 1'b0;
    end else begin
      if (push) begin
        rd_data  <= word;
        rx_ready <= 1'b1;
      end else if (rd_en) begin
        rx_ready <= 1'b0;
      end
      if (rd_en && !rx_ready) udr_flag <= 1'b1;
      if (ovr_evt)            ovr_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/pdm_capture_frontend.sv
module pdm_capture_frontend
  import pdmcap_pkg::*;
#(
  parameter int NCH      = 4,
  parameter int DIV_HALF = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sw_rst,
  input  logic [NCH-1:0]          ch_en,
  input  logic [NCH-1:0]          line_sel,
  input  logic [NCH-1:0]          edge_sel,
  output logic                    pdm_clk,
  input  logic [LINES-1:0]        pdm_line,
  output logic                    bit_valid,
  output logic [NCH-1:0]          pdm_bits,
  input  logic                    smp_valid,
  input  logic [NCH*SAMPLE_W-1:0] smp_data,
  input  logic                    rd_en,
  output logic [WORD_W-1:0]       rd_data,
  output logic                    rx_ready,
  output logic                    ovr_flag,
  output logic                    udr_flag
);
  logic              rise_stb, fall_stb;
  logic              seq_valid, seq_ready, push, ovr_evt;
  logic [WORD_W-1:0] seq_word;

  assign seq_ready = !rx_ready;
  assign push      = seq_valid && seq_ready;

  pdmcap_clkgen #(.DIV_HALF(DIV_HALF)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst),
    .pdm_clk(pdm_clk), .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  pdmcap_capture #(.NCH(NCH)) u_capture (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst),
    .rise_stb(rise_stb), .fall_stb(fall_stb), .pdm_line(pdm_line),
    .ch_en(ch_en), .line_sel(line_sel), .edge_sel(edge_sel),
    .bit_valid(bit_valid), .pdm_bits(pdm_bits)
  );

  pdmcap_sequencer #(.NCH(NCH)) u_seq (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst),
    .smp_valid(smp_valid), .smp_data(smp_data), .ch_en(ch_en),
    .out_ready(seq_ready), .out_valid(seq_valid), .out_word(seq_word),
    .ovr_evt(ovr_evt)
  );

  pdmcap_holdreg u_hold (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst),
    .push(push), .word(seq_word), .rd_en(rd_en), .ovr_evt(ovr_evt),
    .rd_data(rd_data), .rx_ready(rx_ready),
    .ovr_flag(ovr_flag), .udr_flag(udr_flag)
  );
endmodule

// File: rtl/pdmcap_checker.sv
module pdmcap_checker #(
  parameter int NCH      = 4,
  parameter int DIV_HALF = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sw_rst,
  input logic       pdm_clk,
  input logic       bit_valid,
  input logic       push,
  input logic       rd_en,
  input logic       rx_ready,
  input logic       ovr_flag,
  input logic       udr_flag,
  input logic       smp_valid,
  input logic [7:0] rd_tag
);
  logic        prev_clk, seen;
  logic [15:0] since;
  logic        chg;

  assign chg = (pdm_clk != prev_clk);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || sw_rst) begin
      prev_clk <= 1'b0;
      seen     <= 1'b0;
      since    <= '0;
    end else begin
      prev_clk <= pdm_clk;
      if (chg) begin
        seen  <= 1'b1;
        since <= 16'd1;
      end else begin
        since <= since + 16'd1;
      end
    end
  end

  assert_half_period_R1: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
    (chg && seen) |-> (since == 16'(DIV_HALF)));

  assert_bit_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
    bit_valid |=> !bit_valid);

  assert_tag_range_R6: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
    push |=> (rd_tag < 8'(NCH)));

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
    (rd_en && rx_ready) |=> !rx_ready);

  assert_push_sets_R7: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
    push |=> rx_ready);

  assert_ovr_cause_R8: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
    $rose(ovr_flag) |-> $past(smp_valid));

  assert_udr_set_R9: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
    (rd_en && !rx_ready) |=> (udr_flag && !rx_ready));

  assert_swrst_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> (!rx_ready && !ovr_flag && !udr_flag && !pdm_clk && !bit_valid));
endmodule

bind pdm_capture_frontend pdmcap_checker #(.NCH(NCH), .DIV_HALF(DIV_HALF)) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .pdm_clk(pdm_clk),
  .bit_valid(bit_valid), .push(push), .rd_en(rd_en), .rx_ready(rx_ready),
  .ovr_flag(ovr_flag), .udr_flag(udr_flag), .smp_valid(smp_valid),
  .rd_tag(rd_data[31:24])
);

// File: tb/tb_pdm_capture_frontend.sv
`timescale 1ns/1ps
module tb_pdm_capture_frontend;
  localparam int NCH = 4;
  localparam int DH  = 4;

  logic clk = 1'b0, rst_n = 1'b0, sw_rst = 1'b0;
  logic [NCH-1:0] ch_en = '1, line_sel = '0, edge_sel = '0;
  logic pdm_clk, bit_valid, smp_valid = 1'b0, rd_en = 1'b0;
  logic [1:0] pdm_line, rbit = '0, fbit = '0;
  logic [NCH-1:0] pdm_bits;
  logic [NCH*24-1:0] smp_data = '0;
  logic [31:0] rd_data;
  logic rx_ready, ovr_flag, udr_flag;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  for (genvar l = 0; l < 2; l++) begin : g_mic
    assign pdm_line[l] = pdm_clk ? fbit[l] : rbit[l];
  end

  pdm_capture_frontend #(.NCH(NCH), .DIV_HALF(DH)) dut (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .ch_en(ch_en),
    .line_sel(line_sel), .edge_sel(edge_sel), .pdm_clk(pdm_clk),
    .pdm_line(pdm_line), .bit_valid(bit_valid), .pdm_bits(pdm_bits),
    .smp_valid(smp_valid), .smp_data(smp_data), .rd_en(rd_en),
    .rd_data(rd_data), .rx_ready(rx_ready), .ovr_flag(ovr_flag),
    .udr_flag(udr_flag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_bitv(input string req);
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (bit_valid) return;
    end
    chk(req, 32'd0, 32'd1);
  endtask

  task automatic wait_ready(input string req);
    for (int k = 0; k < 40; k++) begin
      if (rx_ready) return;
      @(negedge clk);
    end
    chk(req, {31'd0, rx_ready}, 32'd1);
  endtask

  task automatic do_read();
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  function automatic logic [23:0] samp(input int n, input int tag);
    return 24'(24'h13579B + n * 24'h010203 + tag * 24'h0A0B00);
  endfunction

  task automatic send_frame(input int tag);
    for (int n = 0; n < NCH; n++) smp_data[n*24 +: 24] = samp(n, tag);
    smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 pdm_clk", {31'd0, pdm_clk}, 32'd0);
    chk("R11 outputs", {26'd0, bit_valid, pdm_bits, rx_ready},  32'd0);
    chk("R11 flags", {30'd0, ovr_flag, udr_flag}, 32'd0);
    chk("R11 rd_data", rd_data, 32'd0);
    rst_n = 1'b1;

    // R1: clock period
    begin
      int cnt = 0;
      while (!(pdm_clk === 1'b1)) @(negedge clk);
      while (pdm_clk === 1'b1) @(negedge clk);
      while (pdm_clk === 1'b0) @(negedge clk);
      do begin @(negedge clk); cnt++; end while (!(pdm_clk === 1'b0 && cnt > 1) && cnt < 50);
      while (pdm_clk === 1'b0 && cnt < 50) begin @(negedge clk); cnt++; end
      chk("R1 period", cnt, 2 * DH);
    end

    // R2: routing sweep
    wait_bitv("R4 bit_valid timeout");
    for (int c = 0; c < 256; c++) begin
      for (int p = 0; p < 16; p++) begin
        logic [NCH-1:0] exp;
        for (int n = 0; n < NCH; n++) begin
          edge_sel[n] = c[2*n];
          line_sel[n] = c[2*n+1];
        end
        rbit = p[1:0];
        fbit = p[3:2];
        for (int n = 0; n < NCH; n++)
          exp[n] = edge_sel[n] ? fbit[line_sel[n]] : rbit[line_sel[n]];
        wait_bitv("R4 bit_valid timeout");
        chk("R2 routed bits", {28'd0, pdm_bits}, {28'd0, exp});
        @(negedge clk);
        chk("R4 single pulse", {31'd0, bit_valid}, 32'd0);
      end
    end

    // R3: enable masking of bits
    rbit = 2'b11;
    fbit = 2'b11;
    for (int e = 0; e < 16; e++) begin
      ch_en = 4'(e);
      wait_bitv("R4 bit_valid timeout");
      chk("R3 masked bits", {28'd0, pdm_bits}, 32'(e));
    end

    // R5 R6 R3: frames for every enable mask
    for (int e = 0; e < 16; e++) begin
      ch_en = 4'(e);
      send_frame(e);
      for (int n = 0; n < NCH; n++) begin
        if (e[n]) begin
          wait_ready("R5 word missing");
          chk("R6 R5 word", rd_data, {8'(n), samp(n, e)});
          do_read();
          chk("R7 cleared on read", {31'd0, rx_ready}, 32'd0);
        end
      end
      repeat (6) @(negedge clk);
      chk("R3 R5 no extra word", {31'd0, rx_ready}, 32'd0);
    end
    chk("R8 no overrun yet", {31'd0, ovr_flag}, 32'd0);

    // R8: overrun replaces pending words
    ch_en = 4'b0011;
    send_frame(20);
    wait_ready("R8 first word");
    send_frame(21);
    chk("R8 ovr_flag", {31'd0, ovr_flag}, 32'd1);
    chk("R8 kept word", rd_data, {8'd0, samp(0, 20)});
    do_read();
    wait_ready("R8 second word");
    chk("R8 new frame ch0", rd_data, {8'd0, samp(0, 21)});
    do_read();
    wait_ready("R8 third word");
    chk("R8 new frame ch1", rd_data, {8'd1, samp(1, 21)});
    do_read();
    repeat (4) @(negedge clk);

    // R9: underrun
    chk("R9 udr before", {31'd0, udr_flag}, 32'd0);
    do_read();
    chk("R9 udr_flag", {31'd0, udr_flag}, 32'd1);
    chk("R9 rx_ready low", {31'd0, rx_ready}, 32'd0);

    // R10: software reset with a word held and flags set
    send_frame(30);
    wait_ready("R10 word before reset");
    sw_rst = 1'b1;
    @(negedge clk);
    sw_rst = 1'b0;
    chk("R10 cleared", {27'd0, pdm_clk, bit_valid, rx_ready, ovr_flag, udr_flag}, 32'd0);
    repeat (6) @(negedge clk);
    chk("R10 no pending word", {31'd0, rx_ready}, 32'd0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #900000;
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule